// File: doc/BRIEF.md
# Flash Program/Erase Error-Protection Monitor

This block is the error-protection status register of an on-chip flash controller. While the flash sequencer reports that a program or erase operation is under way, the block watches strobes from the CPU and the bus for events that would corrupt that operation. These events are:

- a read that lands in flash space;
- the start of most exception handlers;
- a sleep instruction or software-standby entry;
- handing the bus to another master.

Any of these latches a sticky error flag. The flag drives a protect output that stops the sequencer from doing any further programming or erasing.

Software sees the block as one 8-bit register. Bit 7 is the error flag and is read-only. Bits 6..0 are spare storage that software can read and write. When the flash is disabled, a read of the register returns zero. The flag can only be cleared by the reset input, which covers both pin and watchdog resets, or by hardware standby. All event strobes are single-cycle and are sampled on the rising clock edge.

Top module: `flash_guard_ctl`

## Requirements
- R1: After rst_n is asserted (low), the register reads 0x00 and prot_on is 0. The reset input covers both pin and watchdog resets.
- R2: With flash_en=1, reg_rdata is {flag, spare[6:0]}. With flash_en=0, reg_rdata is 0x00 whatever is stored.
- R3: A cycle with reg_wr=1 loads reg_wdata[6:0] into bits 6..0 at the next rising edge. No software write path to bit 7 exists.
- R4: With pe_active=1, a strobe rd_strobe=1 with rd_in_flash=1 and rd_in_ram_win=0 sets the flag. A read with rd_in_ram_win=1 does not set it, and neither does a read with rd_in_flash=0.
- R5: With pe_active=1, exc_start=1 sets the flag unless exc_kind is one of the following codes, which do not set it:
  - 0: reset;
  - 1: illegal instruction;
  - 2: trap;
  - 3: divide by zero.
- R6: With pe_active=1, either sleep_exec=1 or sw_stby_enter=1 sets the flag.
- R7: With pe_active=1, bus_release=1 sets the flag.
- R8: With pe_active=0, none of the event strobes changes the flag.
- R9: Once set, the flag stays set through any writes and events. Only rst_n low or hw_stby=1 clears it. hw_stby=1 clears the whole register at the next edge.
- R10: sw_stby_enter=1 clears bits 6..0 at the next edge and leaves the flag unchanged, unless the flag is being set in that same cycle. It takes precedence over a write in the same cycle.
- R11: prot_on equals the stored flag at all times, whatever flash_en is.
- R12: When a write and a flag-setting event arrive in the same cycle, the flag is set and bits 6..0 take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (pin or watchdog) |
| hw_stby | input | 1 | Hardware standby; clears the register |
| flash_en | input | 1 | Flash enabled; when low, reads return zero |
| pe_active | input | 1 | Program or erase operation in progress |
| rd_strobe | input | 1 | CPU read cycle (data, vector or fetch) |
| rd_in_flash | input | 1 | Read address decodes to flash space |
| rd_in_ram_win | input | 1 | Read address hits the RAM window over flash space |
| exc_start | input | 1 | Exception handling begins |
| exc_kind | input | 3 | Exception class code (0 reset, 1 illegal, 2 trap, 3 divide by zero) |
| sleep_exec | input | 1 | Sleep instruction executed |
| sw_stby_enter | input | 1 | Software standby entered |
| bus_release | input | 1 | Bus granted to another master |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 7 | Write data for bits 6..0 |
| reg_rdata | output | 8 | Register read data |
| prot_on | output | 1 | Error protection active; blocks program/erase |

## Verification
A software write to the spare bits and a hardware event that sets the flag can land in the same clock edge. The bench provokes this by driving reg_wr together with bus_release during an active operation. It expects the read value to combine the set flag with the freshly written spare bits.

Software-standby entry also meets a pending write in one cycle: the spare bits must then clear while the flag is set. The bench checks both cases one cycle after the shared edge, through reg_rdata and prot_on.

// File: rtl/flash_guard_ctl.sv
module flash_guard_ctl #(
  parameter int KIND_W = 3,
  parameter int SPARE_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_stby,
  input  logic               flash_en,
  input  logic               pe_active,
  input  logic               rd_strobe,
  input  logic               rd_in_flash,
  input  logic               rd_in_ram_win,
  input  logic               exc_start,
  input  logic [KIND_W-1:0]  exc_kind,
  input  logic               sleep_exec,
  input  logic               sw_stby_enter,
  input  logic               bus_release,
  input  logic               reg_wr,
  input  logic [SPARE_W-1:0] reg_wdata,
  output logic [SPARE_W:0]   reg_rdata,
  output logic               prot_on
);
  localparam logic [KIND_W-1:0] K_RESET = KIND_W'(0);
  localparam logic [KIND_W-1:0] K_ILL   = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_TRAP  = KIND_W'(2);
  localparam logic [KIND_W-1:0] K_DIV   = KIND_W'(3);

  logic               flag_q;
  logic [SPARE_W-1:0] spare_q;
  logic               rd_hit, exc_hit, set_ev;

  assign rd_hit  = rd_strobe && rd_in_flash && !rd_in_ram_win;
  assign exc_hit = exc_start && !(exc_kind inside {K_RESET, K_ILL, K_TRAP, K_DIV});
  assign set_ev  = pe_active && (rd_hit || exc_hit || sleep_exec || sw_stby_enter || bus_release);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      spare_q <= '0;
    end else if (hw_stby) begin
      flag_q  <= 1'b0;
      spare_q <= '0;
    end else begin
      if (set_ev) flag_q <= 1'b1;
      if (sw_stby_enter) spare_q <= '0;
      else if (reg_wr)   spare_q <= reg_wdata;
    end
  end

  assign reg_rdata = flash_en ? {flag_q, spare_q} : '0;
  assign prot_on   = flag_q;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int KIND_W = 3,
  parameter int SPARE_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hw_stby,
  input logic               flash_en,
  input logic               pe_active,
  input logic               rd_strobe,
  input logic               rd_in_flash,
  input logic               rd_in_ram_win,
  input logic               exc_start,
  input logic [KIND_W-1:0]  exc_kind,
  input logic               sleep_exec,
  input logic               sw_stby_enter,
  input logic               bus_release,
  input logic               reg_wr,
  input logic [SPARE_W-1:0] reg_wdata,
  input logic [SPARE_W:0]   reg_rdata,
  input logic               prot_on
);
  // R2
  disabled_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en |-> reg_rdata == '0);

  // R11
  prot_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_en |-> reg_rdata[SPARE_W] == prot_on);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on && !hw_stby |=> prot_on);

  // R9
  hw_stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> !prot_on);

  // R8
  idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_active && !prot_on |=> !prot_on);

  // R7
  bus_release_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_active && bus_release && !hw_stby |=> prot_on);

  // R6
  sleep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_active && (sleep_exec || sw_stby_enter) && !hw_stby |=> prot_on);

  // R10
  sw_stby_spare_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stby_enter && flash_en |=> !flash_en || reg_rdata[SPARE_W-1:0] == '0);
endmodule

bind flash_guard_ctl flash_guard_chk #(.KIND_W(KIND_W), .SPARE_W(SPARE_W)) u_chk (.*);

// File: tb/test_flash_guard_ctl.sv
`timescale 1ns/1ps
module test_flash_guard_ctl;
  logic clk = 1'b0, rst_n = 1'b0, hw_stby = 1'b0, flash_en = 1'b1, pe_active = 1'b0;
  logic rd_strobe = 1'b0, rd_in_flash = 1'b0, rd_in_ram_win = 1'b0, exc_start = 1'b0;
  logic [2:0] exc_kind = '0;
  logic sleep_exec = 1'b0, sw_stby_enter = 1'b0, bus_release = 1'b0, reg_wr = 1'b0;
  logic [6:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic prot_on;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  flash_guard_ctl i_flash_guard_ctl (.*);

  typedef struct packed {
    logic pe, rd, infl, ramw, exc;
    logic [2:0] kind;
    logic slp, swst, brel, wr;
    logic [6:0] wdata;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R8 idle
    '{1'b1,1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,7'h00,8'h80}, // R4 flash read
    '{1'b1,1'b1,1'b1,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R4 RAM window
    '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R4 non-flash read
    '{1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R8 read idle
    '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R5 reset
    '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R5 illegal
    '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R5 trap
    '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R5 div zero
    '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,7'h00,8'h80}, // R5 other
    '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,7'h00,8'h80}, // R5 other
    '{1'b0,1'b0,1'b0,1'b0,1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,7'h00,8'h00}, // R8 exc idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,7'h00,8'h80}, // R6 sleep
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,7'h00,8'h80}, // R6 sw standby
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,7'h00,8'h00}, // R8 sleep idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,7'h00,8'h80}, // R7 bus release
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,7'h00,8'h00}, // R8 release idle
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,7'h7F,8'h7F}, // R3 write
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,7'h55,8'hD5}  // R12 write + set
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hw_stby = 0; pe_active = 0; rd_strobe = 0; rd_in_flash = 0; rd_in_ram_win = 0;
    exc_start = 0; exc_kind = '0; sleep_exec = 0; sw_stby_enter = 0; bus_release = 0;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R1 reset prot", {7'h0, prot_on}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      hw_stby = 1; tick();
      pe_active = TBL[i].pe; rd_strobe = TBL[i].rd; rd_in_flash = TBL[i].infl;
      rd_in_ram_win = TBL[i].ramw; exc_start = TBL[i].exc; exc_kind = TBL[i].kind;
      sleep_exec = TBL[i].slp; sw_stby_enter = TBL[i].swst; bus_release = TBL[i].brel;
      reg_wr = TBL[i].wr; reg_wdata = TBL[i].wdata;
      tick();
      check($sformatf("vector %0d rdata", i), reg_rdata, TBL[i].exp);
      check($sformatf("R11 vector %0d prot", i), {7'h0, prot_on}, {7'h0, TBL[i].exp[7]});
    end

    // R9 sticky against writes and idle cycles
    hw_stby = 1; tick();
    pe_active = 1; bus_release = 1; tick();
    reg_wr = 1; reg_wdata = 7'h00; tick();
    tick();
    check("R9 sticky after write", reg_rdata, 8'h80);

    // R2 disabled flash reads zero, R11 prot still high
    flash_en = 0; #0.1;
    check("R2 disabled read", reg_rdata, 8'h00);
    check("R11 prot while disabled", {7'h0, prot_on}, 8'h01);
    flash_en = 1;

    // R10 software standby clears spare, keeps flag, beats a write
    reg_wr = 1; reg_wdata = 7'h7F; tick();
    check("R3 spare write with flag", reg_rdata, 8'hFF);
    sw_stby_enter = 1; reg_wr = 1; reg_wdata = 7'h2A; tick();
    check("R10 sw standby", reg_rdata, 8'h80);

    // R10 with flag clear and idle operation: spare cleared, flag stays clear
    hw_stby = 1; tick();
    reg_wr = 1; reg_wdata = 7'h41; tick();
    sw_stby_enter = 1; tick();
    check("R10 sw standby idle", reg_rdata, 8'h00);

    // R9 hardware standby clears flag and spare
    pe_active = 1; sleep_exec = 1; reg_wr = 1; reg_wdata = 7'h33; tick();
    check("R12 sleep + write", reg_rdata, 8'hB3);
    hw_stby = 1; pe_active = 1; bus_release = 1; tick();
    check("R9 hw standby wins", reg_rdata, 8'h00);

    // R1 reset clears a set flag
    pe_active = 1; rd_strobe = 1; rd_in_flash = 1; reg_wr = 1; reg_wdata = 7'h11; tick();
    check("R4 set before reset", reg_rdata, 8'h91);
    rst_n = 0; #1;
    check("R1 async reset", reg_rdata, 8'h00);
    check("R1 reset prot", {7'h0, prot_on}, 8'h00);
    @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 after release", reg_rdata, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule